// File: doc/BRIEF.md
# Pipelined Burst SRAM Control Core

This block is a synthesizable model of a synchronous, pipelined, 32-bit-wide SRAM with an internal burst counter. Every control input except the output enable is sampled on the rising clock edge. The inputs are the chip enables, two address strobes, burst advance and the write controls.

Each cycle the core classifies the access as one of these:
- deselect
- begin read
- begin write
- continue at the next burst address
- suspend at the current burst address

Writes go to the selected byte lanes of the array in the same cycle. Reads are captured into an output register and appear one clock after the address is taken.

The two strobes obey different rules:
- The processor-side strobe always starts a read, and a high primary chip enable masks it completely.
- The controller-side strobe can start either a read or a write. With the primary chip enable high, it deselects the device.

The secondary enables are examined only on strobe cycles. Byte enables and write data are taken from the cycle in which the write happens, not from the cycle that loaded the address. As a result, a read begun by the processor strobe can be turned into a write at the same address on the following cycle.

The bus is modelled as a driven-data output plus a drive-enable flag instead of a tristate. The output enable gates that flag without passing through any register. A static mode input picks the burst order. The interleaved order steps through the two low address bits by exclusive-OR with the count. The linear order adds the count modulo the burst length.

Top module: `psram_core`

## Requirements
- R1: With `ce1_n` high, `adsp_n` has no effect: the cycle behaves as if `adsp_n` were high. With `ce1_n` high and `adsc_n` low, the device is deselected. From the next cycle `dout_en` stays 0, and later cycles with neither strobe low access nothing until a new strobe selects the device.
- R2: `ce2` (active high) and `ce3_n` (active low) are examined only in a cycle where a strobe is accepted. If either is inactive there, the device is deselected. Their values in cycles with no strobe have no effect.
- R3: A cycle with `adsp_n` low and `ce1_n` low (and valid secondary enables) loads `addr` and reads, whatever `gw_n`, `bwe_n`, `bw_n` and `din` are. The array is left unchanged.
- R4: A cycle with `adsc_n` low, `adsp_n` high or masked, `ce1_n` low and valid secondary enables loads `addr`. It writes if the byte mask of R8 is non-zero and reads otherwise.
- R5: While the device is selected, a cycle with no accepted strobe reads or writes, according to R8. With `adv_n` low it uses the next burst address; with `adv_n` high it uses the current one.
- R6: With `seq_xor` = 1, the two low address bits of the k-th access in a burst (k = 0..3) are start XOR k. The upper bits stay at those of the loaded address.
- R7: With `seq_xor` = 0, the two low address bits are (start + k) mod 4. The burst wraps within the aligned group of four words.
- R8: The byte mask is 4'b1111 when `gw_n` is 0. Otherwise it is the inverse of `bw_n` when `bwe_n` is 0, and 0 (meaning a read) otherwise. Mask bit n writes `din[8n+7:8n]`.
- R9: A read accepted on a clock edge puts the addressed word on `dout` after that edge, with `dout_en` = 1 while `oe_n` is low.
- R10: `dout_en` is 0 after a write or deselect cycle, and at any moment `oe_n` is high, with no clock needed. `dout` reads 0 whenever `dout_en` is 0.
- R11: Synchronous reset leaves the device deselected with `dout_en` = 0.
- R12: Byte enables and data are taken in the write cycle itself. After a processor-strobe read at address A, a no-strobe cycle with `adv_n` high and a write mask writes A using that cycle's `din` and `bw_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | External word address |
| ce1_n | input | 1 | Primary chip enable, active low |
| ce2 | input | 1 | Secondary chip enable, active high |
| ce3_n | input | 1 | Secondary chip enable, active low |
| adsp_n | input | 1 | Processor-side address strobe, active low |
| adsc_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bw_n | input | 4 | Per-byte write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| seq_xor | input | 1 | Burst order: 1 interleaved, 0 linear |
| din | input | 32 | Write data |
| dout | output | 32 | Read data, 0 when not driven |
| dout_en | output | 1 | High when the bus is driven |

## Verification
The bench targets wrap-around of both burst orders from a non-zero start. A counter that carried into the upper address bits, or that used the wrong order, would return a word from outside the aligned group.

It issues a processor strobe with write controls and fresh data. A design that honoured the write controls there would corrupt the array, and a later read exposes this.

It also checks the following:
- The primary enable masking the processor strobe. A design that took the strobe anyway would restart the burst.
- A deselect issued on the controller strobe. A design that kept its state would go on driving the bus.
- Secondary enables toggled in mid-burst. A design that sampled them every cycle would drop the burst.
- A write begun at the current address after a processor read. A design that latched byte enables with the address would write no bytes.
- The output enable raised between clock edges. A design that registered it would keep driving until the next edge.

// File: rtl/psram_pkg.sv
package psram_pkg;

    localparam int LANE_W    = 8;
    localparam int NUM_LANES = 4;
    localparam int DATA_W    = LANE_W * NUM_LANES;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef struct packed {
        logic load;   // take the external address this cycle
        logic step;   // advance the burst counter this cycle
        op_e  op;     // access performed this cycle
    } ctl_t;

    // Byte lanes written this cycle; zero means the access is a read.
    function automatic logic [NUM_LANES-1:0] lane_mask(
        input logic                 gw_n,
        input logic                 bwe_n,
        input logic [NUM_LANES-1:0] bw_n
    );
        if (!gw_n)
            return {NUM_LANES{1'b1}};
        else if (!bwe_n)
            return ~bw_n;
        else
            return '0;
    endfunction

endpackage

// File: rtl/psram_ctrl.sv
module psram_ctrl
    import psram_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ce1_n,
    input  logic                 ce2,
    input  logic                 ce3_n,
    input  logic                 adsp_n,
    input  logic                 adsc_n,
    input  logic                 adv_n,
    input  logic [NUM_LANES-1:0] wmask,
    output ctl_t                 ctl
);

    logic engaged_q;
    logic engaged_d;
    logic sec_ok;
    logic is_wr;

    assign sec_ok = ce2 & ~ce3_n;
    assign is_wr  = |wmask;

    always_comb begin
        ctl       = '{load: 1'b0, step: 1'b0, op: OP_IDLE};
        engaged_d = engaged_q;
        if (!adsp_n && !ce1_n) begin
            // processor strobe: always a read, secondary enables checked here
            if (sec_ok) begin
                ctl.load  = 1'b1;
                ctl.op    = OP_READ;
                engaged_d = 1'b1;
            end else begin
                engaged_d = 1'b0;
            end
        end else if (!adsc_n) begin
            // controller strobe: primary enable high deselects
            if (!ce1_n && sec_ok) begin
                ctl.load  = 1'b1;
                ctl.op    = is_wr ? OP_WRITE : OP_READ;
                engaged_d = 1'b1;
            end else begin
                engaged_d = 1'b0;
            end
        end else if (engaged_q) begin
            ctl.step = ~adv_n;
            ctl.op   = is_wr ? OP_WRITE : OP_READ;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            engaged_q <= 1'b0;
        else
            engaged_q <= engaged_d;
    end

    AST_ADSP_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
        (!adsp_n && !ce1_n) |-> (ctl.op != OP_WRITE)); // R3

    AST_CE1_DESELECT: assert property (@(posedge clk) disable iff (rst)
        (!adsc_n && adsp_n && ce1_n) |=> (ctl.op == OP_IDLE || !adsp_n || !adsc_n)); // R1

endmodule

// File: rtl/psram_burst.sv
module psram_burst #(
    parameter int ADDR_W    = 10,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic              seq_xor,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] addr_used
);

    localparam int CNT_W = $clog2(BURST_LEN);

    logic [ADDR_W-1:0] start_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_d;
    logic [ADDR_W-1:0] base;
    logic [CNT_W-1:0]  low;

    always_comb begin
        base = load ? ext_addr : start_q;
        if (load)
            cnt_d = '0;
        else if (step)
            cnt_d = cnt_q + 1'b1;
        else
            cnt_d = cnt_q;
    end

    generate
        if (CNT_W > 0) begin : g_order
            always_comb begin
                if (seq_xor)
                    low = base[CNT_W-1:0] ^ cnt_d;
                else
                    low = base[CNT_W-1:0] + cnt_d;
            end
            assign addr_used = {base[ADDR_W-1:CNT_W], low};
        end else begin : g_flat
            assign low       = '0;
            assign addr_used = base;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            cnt_q   <= '0;
        end else begin
            if (load)
                start_q <= ext_addr;
            cnt_q <= cnt_d;
        end
    end

    AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (rst)
        (!load && !step && !$past(rst) && $stable(seq_xor)) |-> (addr_used == $past(addr_used))); // R5

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
        (step && !load && !$past(rst)) |-> (addr_used[ADDR_W-1:CNT_W] == $past(addr_used[ADDR_W-1:CNT_W]))); // R7

endmodule

// File: rtl/psram_array.sv
module psram_array
    import psram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  op_e                  op,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NUM_LANES-1:0] wmask,
    input  logic [DATA_W-1:0]    din,
    output logic [DATA_W-1:0]    q,
    output logic                 valid
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] rd_word;

    genvar g;
    generate
        for (g = 0; g < NUM_LANES; g++) begin : g_lane
            logic [LANE_W-1:0] bank [DEPTH];

            always_ff @(posedge clk) begin
                if (op == OP_WRITE && wmask[g])
                    bank[addr] <= din[g*LANE_W +: LANE_W];
            end

            assign rd_word[g*LANE_W +: LANE_W] = bank[addr];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            q     <= '0;
        end else begin
            valid <= (op == OP_READ);
            if (op == OP_READ)
                q <= rd_word;
        end
    end

endmodule

// File: rtl/psram_core.sv
module psram_core
    import psram_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int BURST_LEN = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 ce1_n,
    input  logic                 ce2,
    input  logic                 ce3_n,
    input  logic                 adsp_n,
    input  logic                 adsc_n,
    input  logic                 adv_n,
    input  logic                 gw_n,
    input  logic                 bwe_n,
    input  logic [NUM_LANES-1:0] bw_n,
    input  logic                 oe_n,
    input  logic                 seq_xor,
    input  logic [DATA_W-1:0]    din,
    output logic [DATA_W-1:0]    dout,
    output logic                 dout_en
);

    ctl_t                 ctl;
    logic [NUM_LANES-1:0] wmask;
    logic [ADDR_W-1:0]    addr_used;
    logic [DATA_W-1:0]    q;
    logic                 valid;

    assign wmask = lane_mask(gw_n, bwe_n, bw_n);

    psram_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .ce1_n  (ce1_n),
        .ce2    (ce2),
        .ce3_n  (ce3_n),
        .adsp_n (adsp_n),
        .adsc_n (adsc_n),
        .adv_n  (adv_n),
        .wmask  (wmask),
        .ctl    (ctl)
    );

    psram_burst #(
        .ADDR_W    (ADDR_W),
        .BURST_LEN (BURST_LEN)
    ) u_burst (
        .clk       (clk),
        .rst       (rst),
        .load      (ctl.load),
        .step      (ctl.step),
        .seq_xor   (seq_xor),
        .ext_addr  (addr),
        .addr_used (addr_used)
    );

    psram_array #(
        .ADDR_W (ADDR_W)
    ) u_array (
        .clk   (clk),
        .rst   (rst),
        .op    (ctl.op),
        .addr  (addr_used),
        .wmask (wmask),
        .din   (din),
        .q     (q),
        .valid (valid)
    );

    // output enable gates the registered data without a clock
    assign dout_en = valid & ~oe_n;
    assign dout    = dout_en ? q : '0;

    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (rst)
        (ctl.op == OP_READ) |=> (oe_n || dout_en)); // R9

    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (ctl.op == OP_WRITE) |=> !dout_en); // R10

    AST_DESEL_SILENT: assert property (@(posedge clk) disable iff (rst)
        (!adsc_n && ce1_n) |=> !dout_en); // R1

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> !dout_en); // R11

endmodule

// File: tb/psram_core_test.sv
module psram_core_test;

    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          ce1_n = 1'b1, ce2 = 1'b1, ce3_n = 1'b0;
    logic          adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
    logic          gw_n = 1'b1, bwe_n = 1'b1;
    logic [3:0]    bw_n = 4'hF;
    logic          oe_n = 1'b0, seq_xor = 1'b0;
    logic [31:0]   din = '0;
    logic [31:0]   dout;
    logic          dout_en;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    bit done    = 0;

    // bench reference state
    logic [31:0]   mem_m [DEPTH];
    bit            m_eng = 0;
    logic [AW-1:0] m_start = '0;
    logic [1:0]    m_cnt = '0;
    bit            m_valid = 0;
    logic [31:0]   m_q = '0;

    psram_core #(.ADDR_W(AW), .BURST_LEN(4)) uut (
        .clk(clk), .rst(rst), .addr(addr), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n),
        .bw_n(bw_n), .oe_n(oe_n), .seq_xor(seq_xor), .din(din), .dout(dout), .dout_en(dout_en)
    );

    always #10 clk = ~clk;   // 50 MHz

    function automatic logic [31:0] pattern(input int a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A0000;
    endfunction

    function automatic logic [3:0] exp_mask();
        if (!gw_n) return 4'hF;
        if (!bwe_n) return ~bw_n;
        return 4'h0;
    endfunction

    function automatic logic [AW-1:0] burst_addr(input logic [AW-1:0] s, input logic [1:0] k);
        logic [1:0] lo;
        lo = seq_xor ? (s[1:0] ^ k) : (s[1:0] + k);
        return {s[AW-1:2], lo};
    endfunction

    task automatic model_edge();
        logic [3:0]    mk;
        logic [AW-1:0] a;
        int            op;   // 0 idle, 1 read, 2 write
        mk = exp_mask();
        op = 0;
        a  = '0;
        if (!adsp_n && !ce1_n) begin
            if (ce2 && !ce3_n) begin
                m_eng = 1; m_start = addr; m_cnt = 0; a = addr; op = 1;
            end else m_eng = 0;
        end else if (!adsc_n) begin
            if (!ce1_n && ce2 && !ce3_n) begin
                m_eng = 1; m_start = addr; m_cnt = 0; a = addr; op = (mk != 0) ? 2 : 1;
            end else m_eng = 0;
        end else if (m_eng) begin
            if (!adv_n) m_cnt = m_cnt + 2'd1;
            a  = burst_addr(m_start, m_cnt);
            op = (mk != 0) ? 2 : 1;
        end
        if (op == 2) begin
            for (int b = 0; b < 4; b++)
                if (mk[b]) mem_m[a][b*8 +: 8] = din[b*8 +: 8];
        end
        m_valid = (op == 1);
        if (op == 1) m_q = mem_m[a];
    endtask

    task automatic check(input string tag);
        bit          e_en;
        logic [31:0] e_d;
        e_en = m_valid && !oe_n;
        e_d  = e_en ? m_q : 32'h0;
        vectors++;
        if (dout_en !== e_en || dout !== e_d) begin
            errors++;
            $display("FAIL %s: dout_en=%0b dout=%h expected dout_en=%0b dout=%h",
                     tag, dout_en, dout, e_en, e_d);
        end
    endtask

    task automatic step(input string tag, input bit do_check);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (do_check) check(tag);
    endtask

    task automatic quiet();
        adsp_n = 1; adsc_n = 1; adv_n = 1; ce1_n = 0; ce2 = 1; ce3_n = 0;
        gw_n = 1; bwe_n = 1; bw_n = 4'hF; oe_n = 0;
    endtask

    task automatic adsc_read(input int a, input string tag);
        quiet(); adsc_n = 0; addr = AW'(a);
        step(tag, 1);
        quiet();
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R11: reset state
        repeat (3) @(negedge clk);
        rst = 0;
        step("R11", 1);

        // fill the array with ADSC global writes (R4, R8)
        for (int a = 0; a < DEPTH; a++) begin
            quiet(); adsc_n = 0; gw_n = 0; addr = AW'(a); din = pattern(a);
            step("R10", a < 4);
        end
        quiet();
        for (int a = 0; a < DEPTH; a++) mem_m[a] = pattern(a);
        adsc_read(37, "R4");

        // R7: linear burst from low bits 01, wrapping after four
        seq_xor = 0;
        adsc_read(5, "R7");
        for (int k = 0; k < 4; k++) begin adv_n = 0; step("R7", 1); end

        // R6: interleaved burst from low bits 10 via processor strobe
        seq_xor = 1;
        quiet(); adsp_n = 0; addr = AW'(30); step("R6", 1); quiet();
        for (int k = 0; k < 4; k++) begin adv_n = 0; step("R6", 1); end

        // R5: suspend holds the current word
        adv_n = 1; step("R5", 1); step("R5", 1);

        // R10: output enable acts between clock edges
        oe_n = 1; #2; check("R10");
        oe_n = 0; #2; check("R10");

        // R3: processor strobe with write controls stays a read
        quiet(); adsp_n = 0; gw_n = 0; din = 32'hDEADBEEF; addr = AW'(100);
        step("R3", 1);
        adsc_read(100, "R3");

        // R12: read at A, then write byte 0 at the current address
        quiet(); adsp_n = 0; addr = AW'(200); step("R12", 1);
        quiet(); bwe_n = 0; bw_n = 4'b1110; din = 32'h112233C4; step("R12", 1);
        adsc_read(200, "R12");

        // R8: partial byte masks and a read with bwe_n high
        quiet(); adsc_n = 0; bwe_n = 0; bw_n = 4'b1010; addr = AW'(300); din = 32'hA1B2C3D4;
        step("R8", 1);
        adsc_read(300, "R8");
        quiet(); adsc_n = 0; bwe_n = 1; bw_n = 4'h0; addr = AW'(301); din = 32'hFFFFFFFF;
        step("R8", 1);
        adsc_read(301, "R8");

        // R1: processor strobe masked by ce1_n, burst continues
        seq_xor = 0;
        adsc_read(400, "R1");
        quiet(); adsp_n = 0; ce1_n = 1; adv_n = 0; addr = AW'(900); step("R1", 1);
        quiet(); adsc_n = 0; ce1_n = 1; step("R1", 1);
        quiet(); adv_n = 0; gw_n = 0; din = 32'h0BADF00D; step("R1", 1);
        quiet(); step("R1", 1);
        adsc_read(402, "R1");

        // R2: secondary enables ignored mid-burst, honoured on a strobe
        adsc_read(500, "R2");
        quiet(); ce2 = 0; ce3_n = 1; adv_n = 0; step("R2", 1);
        quiet(); adsc_n = 0; ce3_n = 1; addr = AW'(501); step("R2", 1);
        quiet(); adsp_n = 0; ce2 = 0; addr = AW'(502); step("R2", 1);
        quiet(); step("R2", 1);

        // constrained random mix
        for (int n = 0; n < 4000; n++) begin
            if (n % 500 == 0) seq_xor = $urandom_range(0, 1);
            adsp_n = ($urandom_range(0, 99) >= 15);
            adsc_n = ($urandom_range(0, 99) >= 15);
            ce1_n  = ($urandom_range(0, 99) >= 80);
            ce2    = ($urandom_range(0, 99) < 90);
            ce3_n  = ($urandom_range(0, 99) >= 90);
            adv_n  = $urandom_range(0, 1);
            gw_n   = ($urandom_range(0, 99) >= 10);
            bwe_n  = ($urandom_range(0, 99) >= 30);
            bw_n   = 4'($urandom_range(0, 15));
            oe_n   = ($urandom_range(0, 99) >= 85);
            addr   = AW'($urandom_range(0, DEPTH - 1));
            din    = $urandom;
            @(posedge clk);
            model_edge();
            @(negedge clk);
            check(m_valid ? "R9" : "R10");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule